// File: doc/BRIEF.md
# Bus-Slave Wake-Up and Clock-Presence Controller

This block is the clock-slave end of a serial subscriber bus with a power-saving mode. Its upstream data line is open-drain. When the bus is deactivated the block releases the line, and the external pull-up holds it High. The local processor can request wake-up by setting an activation bit. The block answers by pulling the line Low while the master's clocks are still stopped, which asks the master to start them.

The block watches the received bus clock and decides, against a local reference clock, whether bus clocks are present. A burst of rising edges packed closely enough counts as clocks arriving. The block then gives a one-cycle timing-request interrupt and enters the active state. In the active state the line carries the transmit bit. The master may also start the clocks without any request, and the block goes active in the same way. When the master stops the clocks for long enough, the block falls back to idle and releases the line.

Top module: `bus_wake_slave`

## Requirements
- R1: After reset the line is released (`line_pull_low`=0, `line_level`=1) and `timing_irq` is 0.
- R2: A 0-to-1 change of `act_req` while idle and without clocks makes the block pull the line Low (`line_pull_low`=1, `line_level`=0) from the second reference edge on.
- R3: Dropping `act_req` while the wake-up request is pending, before any clocks are seen, releases the line again.
- R4: While a wake-up request is pending, EDGE_COUNT rising edges of `bus_clk`, all within WINDOW_CYCLES reference cycles counted from the first edge, move the block to active and produce exactly one `timing_irq` pulse.
- R5: The same edge burst while idle with no request also moves the block to active with exactly one `timing_irq` pulse, because the master may start activation.
- R6: While active, the line follows `tx_bit`. A 0 bit pulls it Low (`line_pull_low`=1, `line_level`=0), and a 1 bit releases it (`line_pull_low`=0, `line_level`=1).
- R7: While active, LOSS_CYCLES reference cycles with no rising edge of `bus_clk` return the block to idle with the line released and no interrupt.
- R8: Rising edges spaced wider than the window, so that fewer than EDGE_COUNT fall in any one window, never activate the block. The line stays released and no interrupt is given.
- R9: Changes of `act_req` while active have no effect. The line keeps following `tx_bit`.
- R10: `timing_irq` is never high for two reference cycles in a row.
- R11: After clock loss, a level of `act_req` that is still held at 1 does not restart the wake-up request. Only a new 0-to-1 change does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| act_req | input | 1 | Processor activation bit |
| bus_clk | input | 1 | Bus clock received from the upstream master (asynchronous) |
| tx_bit | input | 1 | Serial transmit data for the active state |
| line_pull_low | output | 1 | Open-drain enable: 1 drives the line Low, 0 releases it |
| line_level | output | 1 | Level the line shows with the pull-up (0 when pulled Low) |
| timing_irq | output | 1 | One-cycle pulse on entry to the active state |

## Verification
The hardest case to reach is the rejection of edges that arrive too sparsely. The bench has to show that edges are present and still never add up to activation, and that takes long stretches of slow bus clock. The generator is run with a half period of 40 reference cycles for several hundred cycles, so every window holds only a single edge. Every cycle is watched for an interrupt or a drive. A second subtle point is the held activation bit after clock loss. The bench keeps the bit high through the loss and checks that the line stays released until the bit is cycled.

// File: rtl/bus_wake_slave.sv
module bus_wake_slave #(
  parameter int EDGE_COUNT    = 4,
  parameter int WINDOW_CYCLES = 64,
  parameter int LOSS_CYCLES   = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_req,
  input  logic bus_clk,
  input  logic tx_bit,
  output logic line_pull_low,
  output logic line_level,
  output logic timing_irq
);

  localparam int EW = $clog2(EDGE_COUNT + 1);
  localparam int WW = $clog2(WINDOW_CYCLES + 1);
  localparam int LW = $clog2(LOSS_CYCLES + 1);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_ACT} state_t;

  state_t        st;
  logic [2:0]    bsync;
  logic          act_q;
  logic [EW-1:0] ecnt;
  logic [WW-1:0] wcnt;
  logic [LW-1:0] gap;

  wire bedge   = bsync[1] & ~bsync[2];
  wire act_set = act_req & ~act_q;
  wire expire  = (ecnt != '0) && (wcnt == WW'(WINDOW_CYCLES - 1));
  wire detect  = bedge && (ecnt == EW'(EDGE_COUNT - 1)) && !expire;
  wire lost    = !bedge && (gap == LW'(LOSS_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bsync <= '0;
      act_q <= 1'b0;
    end else begin
      bsync <= {bsync[1:0], bus_clk};
      act_q <= act_req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ecnt <= '0;
      wcnt <= '0;
    end else if (st == S_ACT || detect) begin
      ecnt <= '0;
      wcnt <= '0;
    end else if (bedge) begin
      if (expire || ecnt == '0) begin
        ecnt <= EW'(1);
        wcnt <= '0;
      end else begin
        ecnt <= ecnt + EW'(1);
        wcnt <= wcnt + WW'(1);
      end
    end else if (expire) begin
      ecnt <= '0;
      wcnt <= '0;
    end else if (ecnt != '0) begin
      wcnt <= wcnt + WW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      gap <= '0;
    else if (st != S_ACT || bedge)   gap <= '0;
    else if (!lost)                  gap <= gap + LW'(1);
    else                             gap <= '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      timing_irq <= 1'b0;
    end else begin
      timing_irq <= 1'b0;
      case (st)
        S_IDLE: if (detect) begin
                  st <= S_ACT;
                  timing_irq <= 1'b1;
                end else if (act_set) st <= S_REQ;
        S_REQ:  if (detect) begin
                  st <= S_ACT;
                  timing_irq <= 1'b1;
                end else if (!act_req) st <= S_IDLE;
        S_ACT:  if (lost) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign line_pull_low = (st == S_REQ) || (st == S_ACT && !tx_bit);
  assign line_level    = ~line_pull_low;

  p_irq_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    timing_irq |=> !timing_irq);

  p_irq_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    timing_irq |-> (st == S_ACT && $past(st) != S_ACT));

  p_req_from_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && act_req && !act_q && !detect) |=> (st == S_REQ));

  p_loss_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ACT && lost) |=> (st == S_IDLE && !timing_irq));

  p_sparse_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_ACT && !bedge) |=> (st != S_ACT));

  p_held_bit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && act_q && !detect) |=> (st == S_IDLE));

endmodule

// File: tb/sim_bus_wake_slave.sv
module sim_bus_wake_slave;
  logic clk = 0, rst_n = 0, act_req = 0, bus_clk = 0, tx_bit = 0;
  logic line_pull_low, line_level, timing_irq;
  int checks = 0, fails = 0, half = 0, irq_cnt = 0, dbl = 0;
  logic irq_prev = 0;

  bus_wake_slave u0 (.clk, .rst_n, .act_req, .bus_clk, .tx_bit,
                     .line_pull_low, .line_level, .timing_irq);

  always #5 clk = ~clk;

  initial forever begin
    if (half > 0) begin
      repeat (half) @(negedge clk);
      bus_clk = ~bus_clk;
    end else begin
      @(negedge clk);
      bus_clk = 0;
    end
  end

  always @(negedge clk) begin
    if (timing_irq) irq_cnt++;
    if (timing_irq && irq_prev) dbl++;
    irq_prev = timing_irq;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic t_reset;
    chk("R1 pull", line_pull_low, 0);
    chk("R1 level", line_level, 1);
    chk("R1 irq", timing_irq, 0);
  endtask

  task automatic t_request_cancel;
    act_req = 1;
    repeat (2) @(negedge clk);
    chk("R2 pull", line_pull_low, 1);
    chk("R2 level", line_level, 0);
    act_req = 0;
    repeat (2) @(negedge clk);
    chk("R3 pull", line_pull_low, 0);
    chk("R3 level", line_level, 1);
  endtask

  task automatic t_sparse;
    int driven = 0;
    int base = irq_cnt;
    half = 40;
    repeat (700) begin
      @(negedge clk);
      if (line_pull_low) driven++;
    end
    half = 0;
    repeat (20) @(negedge clk);
    chk("R8 irq", irq_cnt - base, 0);
    chk("R8 drive", driven, 0);
  endtask

  task automatic t_local_wake;
    int base;
    tx_bit = 0;
    act_req = 1;
    repeat (3) @(negedge clk);
    chk("R2 pending", line_pull_low, 1);
    base = irq_cnt;
    half = 4;
    repeat (150) @(negedge clk);
    chk("R4 irq count", irq_cnt - base, 1);
    tx_bit = 1; #1;
    chk("R6 one pull", line_pull_low, 0);
    chk("R6 one level", line_level, 1);
    tx_bit = 0; #1;
    chk("R6 zero pull", line_pull_low, 1);
    chk("R6 zero level", line_level, 0);
    act_req = 0;
    repeat (50) @(negedge clk);
    chk("R9 still active", line_pull_low, 1);
    act_req = 1;
    repeat (50) @(negedge clk);
    tx_bit = 1; #1;
    chk("R9 follows tx", line_pull_low, 0);
    tx_bit = 0; #1;
    chk("R9 follows tx0", line_pull_low, 1);
    chk("R10 no extra irq", irq_cnt - base, 1);
  endtask

  task automatic t_loss_held;
    int base = irq_cnt;
    tx_bit = 0;
    half = 0;
    repeat (60) @(negedge clk);
    chk("R7 pull", line_pull_low, 0);
    chk("R7 level", line_level, 1);
    chk("R7 irq", irq_cnt - base, 0);
    repeat (50) @(negedge clk);
    chk("R11 held bit", line_pull_low, 0);
    act_req = 0;
    repeat (2) @(negedge clk);
    act_req = 1;
    repeat (2) @(negedge clk);
    chk("R11 new set", line_pull_low, 1);
    act_req = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_remote_wake;
    int base = irq_cnt;
    tx_bit = 0;
    chk("R5 idle before", line_pull_low, 0);
    half = 4;
    repeat (150) @(negedge clk);
    chk("R5 irq count", irq_cnt - base, 1);
    chk("R5 active", line_pull_low, 1);
    half = 0;
    repeat (60) @(negedge clk);
    chk("R7 second loss", line_pull_low, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_request_cancel();
    t_sparse();
    t_local_wake();
    t_loss_held();
    t_remote_wake();
    chk("R10 single cycle", dbl, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule